// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a logical address from a processor into a physical address with a single-level page table. The upper bits of the logical address select a page and the lower bits are an offset inside that page. The page is first compared against a small fully associative translation cache. On a hit, the frame number comes from that cache. On a miss, the unit reads one page-table entry from memory at the table base plus the page number, checks it, and then caches it.

Every request is also checked against a table-length bound, the entry's presence bit and the entry's write permission. A violation ends the request with a one-cycle response that carries a fault flag and a cause code instead of an address.

Software supplies the table base, the table length and a flush pulse. After it changes the base or the length, software is expected to flush the cache.

Top module: `paged_xlate`

## Requirements
- R1: A logical address of LA_W bits (default 4) splits into a page number in bits [LA_W-1:OFF_W] and an offset in bits [OFF_W-1:0] (default OFF_W=2). A successful response drives `rsp_paddr_o = {frame, offset}`, and the offset passes through unchanged.
- R2: A request whose page number is greater than or equal to `ptlr_i` ends with a bound fault (cause 1). It makes no memory read, and its response is valid in the cycle after acceptance.
- R3: A miss within bounds issues exactly one page-table read, at address `ptbr_i + page` with the page zero-extended. The address is held steady until `mem_rd_valid_i`, and the response is valid in the cycle after that handshake.
- R4: A page-table entry holds the present bit in bit 0, the write-permission bit in bit 1 and the frame number in bits [FRAME_W+1:2]. An entry with bit 0 clear ends the request with an invalid fault (cause 2) and is not cached, so the next access to that page reads memory again.
- R5: A write to a page whose write-permission bit is 0 ends with a protection fault (cause 3). A read of the same page succeeds.
- R6: A page already cached is translated without a memory read, and its response is valid in the cycle after acceptance. The cached frame and permission are used even if the entry in memory has since changed.
- R7: A one-cycle `flush_i` pulse empties the whole cache, so the next access to any page reads the table again. A flush takes priority over a fill in the same cycle.
- R8: `rsp_valid_o` is a one-cycle pulse per request. `rsp_fault_o` is high only together with it and only for a nonzero cause. The cause codes are 0 none, 1 bound, 2 invalid and 3 protection.
- R9: A request is accepted only while `req_ready_o` is high. Ready stays low while a table read is outstanding. Base and length are sampled in the acceptance cycle, so later changes do not affect a request already in flight.
- R10: The cache has TLB_N entries (default 4) filled in round-robin order. Only an entry that is present and in bounds is filled, and no page ever matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_addr_i | input | LA_W | Logical address |
| req_write_i | input | 1 | Access is a write |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | FRAME_W+OFF_W | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_cause_o | output | 2 | Fault cause code |
| mem_rd_req_o | output | 1 | Page-table read request |
| mem_rd_addr_o | output | MEM_AW | Page-table entry address |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | FRAME_W+2 | Page-table entry |
| ptbr_i | input | MEM_AW | Page-table base |
| ptlr_i | input | PAGE_W+1 | Page-table length in entries |
| flush_i | input | 1 | Clear all cache entries |

## Verification
A corrupted cache entry shows up in the very next response for that page. It appears either as a wrong frame in the upper address bits, or as a missing or extra memory read, which the bench counts. A stuck or wrong walk state shows up within one request as a response that arrives late or never, or as ready staying low. Sweeping every page, offset, direction, length and two base values over two passes compares each response against the same request made on a miss and then on a hit.

// File: rtl/paged_xlate_pkg.sv
package paged_xlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_BOUND   = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_PROT    = 2'd3
    } xl_cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xl_state_e;

endpackage

// File: rtl/paged_xlate_tlb.sv
module paged_xlate_tlb #(
    parameter int TLB_N   = 4,
    parameter int PAGE_W  = 2,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [PAGE_W-1:0]  lk_page_i,
    output logic               hit_o,
    output logic [FRAME_W-1:0] hit_frame_o,
    output logic               hit_rw_o,
    input  logic               fill_en_i,
    input  logic [PAGE_W-1:0]  fill_page_i,
    input  logic [FRAME_W-1:0] fill_frame_i,
    input  logic               fill_rw_i
);
    localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

    typedef struct packed {
        logic               valid;
        logic [PAGE_W-1:0]  tag;
        logic [FRAME_W-1:0] frame;
        logic               rw;
    } ent_t;

    typedef struct packed {
        ent_t [TLB_N-1:0] ent;
        logic [IDX_W-1:0] vic;
    } tlb_t;

    tlb_t s_d, s_q;
    logic [TLB_N-1:0] hit_vec;
    logic [TLB_N-1:0] valid_vec;

    for (genvar gi = 0; gi < TLB_N; gi++) begin : g_match
        assign hit_vec[gi]   = s_q.ent[gi].valid && (s_q.ent[gi].tag == lk_page_i);
        assign valid_vec[gi] = s_q.ent[gi].valid;
    end

    always_comb begin
        hit_frame_o = '0;
        hit_rw_o    = 1'b0;
        for (int i = 0; i < TLB_N; i++) begin
            if (hit_vec[i]) begin
                hit_frame_o = hit_frame_o | s_q.ent[i].frame;
                hit_rw_o    = hit_rw_o | s_q.ent[i].rw;
            end
        end
    end
    assign hit_o = |hit_vec;

    always_comb begin
        s_d = s_q;
        if (fill_en_i) begin
            s_d.ent[s_q.vic].valid = 1'b1;
            s_d.ent[s_q.vic].tag   = fill_page_i;
            s_d.ent[s_q.vic].frame = fill_frame_i;
            s_d.ent[s_q.vic].rw    = fill_rw_i;
            s_d.vic = (s_q.vic == IDX_W'(TLB_N - 1)) ? '0 : s_q.vic + IDX_W'(1);
        end
        if (flush_i) begin
            for (int i = 0; i < TLB_N; i++) begin
                s_d.ent[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TLB_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_vec == '0)); // R7

endmodule

// File: rtl/paged_xlate_chk.sv
module paged_xlate_chk
    import paged_xlate_pkg::*;
(
    input  logic      in_bound_i,
    input  logic      pte_valid_i,
    input  logic      pte_rw_i,
    input  logic      write_i,
    output xl_cause_e cause_o
);
    always_comb begin
        if (!in_bound_i) begin
            cause_o = CAUSE_BOUND;
        end else if (!pte_valid_i) begin
            cause_o = CAUSE_INVALID;
        end else if (write_i && !pte_rw_i) begin
            cause_o = CAUSE_PROT;
        end else begin
            cause_o = CAUSE_NONE;
        end
    end

    always_comb begin
        assert (!(cause_o == CAUSE_PROT && !write_i)); // R5
    end

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
    import paged_xlate_pkg::*;
#(
    parameter int LA_W    = 4,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3,
    parameter int MEM_AW  = 8,
    parameter int TLB_N   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic [LA_W-1:0]         req_addr_i,
    input  logic                    req_write_i,
    output logic                    rsp_valid_o,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr_o,
    output logic                    rsp_fault_o,
    output logic [1:0]              rsp_cause_o,
    output logic                    mem_rd_req_o,
    output logic [MEM_AW-1:0]       mem_rd_addr_o,
    input  logic                    mem_rd_valid_i,
    input  logic [FRAME_W+1:0]      mem_rd_data_i,
    input  logic [MEM_AW-1:0]       ptbr_i,
    input  logic [LA_W-OFF_W:0]     ptlr_i,
    input  logic                    flush_i
);
    localparam int PAGE_W = LA_W - OFF_W;
    localparam int PA_W   = FRAME_W + OFF_W;
    localparam int LEN_W  = PAGE_W + 1;

    typedef struct packed {
        xl_state_e          st;
        logic [PAGE_W-1:0]  page;
        logic [OFF_W-1:0]   off;
        logic               write;
        logic [MEM_AW-1:0]  rd_addr;
        logic               rsp_valid;
        logic [PA_W-1:0]    rsp_paddr;
        xl_cause_e          rsp_cause;
    } regs_t;

    regs_t s_d, s_q;

    logic [PAGE_W-1:0]  req_page;
    logic [OFF_W-1:0]   req_off;
    logic               in_bound;
    logic               tlb_hit;
    logic [FRAME_W-1:0] tlb_frame;
    logic               tlb_rw;
    logic               pte_valid;
    logic               pte_rw;
    logic [FRAME_W-1:0] pte_frame;
    logic               fill_en;
    logic               chk_inb, chk_valid, chk_rw, chk_wr;
    xl_cause_e          chk_cause;
    logic               idle;

    assign req_page  = req_addr_i[LA_W-1:OFF_W];
    assign req_off   = req_addr_i[OFF_W-1:0];
    assign in_bound  = {1'b0, req_page} < ptlr_i;
    assign pte_valid = mem_rd_data_i[0];
    assign pte_rw    = mem_rd_data_i[1];
    assign pte_frame = mem_rd_data_i[FRAME_W+1:2];
    assign idle      = (s_q.st == ST_IDLE);

    paged_xlate_tlb #(
        .TLB_N   (TLB_N),
        .PAGE_W  (PAGE_W),
        .FRAME_W (FRAME_W)
    ) tlb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .lk_page_i    (req_page),
        .hit_o        (tlb_hit),
        .hit_frame_o  (tlb_frame),
        .hit_rw_o     (tlb_rw),
        .fill_en_i    (fill_en),
        .fill_page_i  (s_q.page),
        .fill_frame_i (pte_frame),
        .fill_rw_i    (pte_rw)
    );

    assign chk_inb   = idle ? in_bound    : 1'b1;
    assign chk_valid = idle ? 1'b1        : pte_valid;
    assign chk_rw    = idle ? tlb_rw      : pte_rw;
    assign chk_wr    = idle ? req_write_i : s_q.write;

    paged_xlate_chk chk_i (
        .in_bound_i  (chk_inb),
        .pte_valid_i (chk_valid),
        .pte_rw_i    (chk_rw),
        .write_i     (chk_wr),
        .cause_o     (chk_cause)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_cause = CAUSE_NONE;
        s_d.rsp_paddr = '0;
        fill_en       = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.page    = req_page;
                    s_d.off     = req_off;
                    s_d.write   = req_write_i;
                    s_d.rd_addr = ptbr_i + MEM_AW'(req_page);
                    if (!in_bound || tlb_hit) begin
                        s_d.rsp_valid = 1'b1;
                        s_d.rsp_cause = chk_cause;
                        if (chk_cause == CAUSE_NONE) begin
                            s_d.rsp_paddr = {tlb_frame, req_off};
                        end
                    end else begin
                        s_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (mem_rd_valid_i) begin
                    s_d.st        = ST_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_cause = chk_cause;
                    fill_en       = pte_valid;
                    if (chk_cause == CAUSE_NONE) begin
                        s_d.rsp_paddr = {pte_frame, s_q.off};
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o   = idle;
    assign mem_rd_req_o  = (s_q.st == ST_WALK);
    assign mem_rd_addr_o = s_q.rd_addr;
    assign rsp_valid_o   = s_q.rsp_valid;
    assign rsp_paddr_o   = s_q.rsp_paddr;
    assign rsp_cause_o   = s_q.rsp_cause;
    assign rsp_fault_o   = s_q.rsp_cause != CAUSE_NONE;

    AST_BOUND_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && ({1'b0, req_addr_i[LA_W-1:OFF_W]} >= ptlr_i))
        |=> (rsp_valid_o && rsp_cause_o == 2'd1 && !mem_rd_req_o)); // R2

    AST_WALK_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_o && !mem_rd_valid_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o))); // R3

    AST_WALK_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_o && mem_rd_valid_i) |=> (rsp_valid_o && !mem_rd_req_o)); // R3

    AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && tlb_hit && in_bound) |=> (rsp_valid_o && !mem_rd_req_o)); // R6

    AST_FAULT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o |-> rsp_valid_o); // R8

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o |=> (!rsp_fault_o || $past(req_valid_i && req_ready_o))); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req_o |-> !req_ready_o); // R9

    AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (mem_rd_req_o && mem_rd_valid_i && mem_rd_data_i[0])); // R10

endmodule

// File: tb/paged_xlate_tb.sv
module paged_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LA_W = 4, OFF_W = 2, FRAME_W = 3, MEM_AW = 8, TLB_N = 4;
    localparam int PAGE_W = LA_W - OFF_W;
    localparam int NPAGE  = 1 << PAGE_W;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid_i, req_ready_o, req_write_i;
    logic [LA_W-1:0] req_addr_i;
    logic rsp_valid_o, rsp_fault_o;
    logic [FRAME_W+OFF_W-1:0] rsp_paddr_o;
    logic [1:0] rsp_cause_o;
    logic mem_rd_req_o;
    logic [MEM_AW-1:0] mem_rd_addr_o;
    logic mem_rd_valid_i;
    logic [FRAME_W+1:0] mem_rd_data_i;
    logic [MEM_AW-1:0] ptbr_i;
    logic [PAGE_W:0] ptlr_i;
    logic flush_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_xlate #(.LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW), .TLB_N(TLB_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_addr_i(req_addr_i), .req_write_i(req_write_i), .rsp_valid_o(rsp_valid_o),
        .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o), .rsp_cause_o(rsp_cause_o),
        .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_valid_i(mem_rd_valid_i),
        .mem_rd_data_i(mem_rd_data_i), .ptbr_i(ptbr_i), .ptlr_i(ptlr_i), .flush_i(flush_i)
    );

    logic [FRAME_W+1:0] pt_mem [256];
    int lat;
    int wait_cnt;
    int reads;
    logic [MEM_AW-1:0] last_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid_i <= 1'b0;
            mem_rd_data_i  <= '0;
            wait_cnt       <= 0;
            reads          <= 0;
            last_addr      <= '0;
        end else if (mem_rd_valid_i) begin
            mem_rd_valid_i <= 1'b0;
        end else if (mem_rd_req_o) begin
            if (wait_cnt >= lat) begin
                mem_rd_valid_i <= 1'b1;
                mem_rd_data_i  <= pt_mem[mem_rd_addr_o];
                reads          <= reads + 1;
                last_addr      <= mem_rd_addr_o;
                wait_cnt       <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit cached [NPAGE];
    int cfr [NPAGE];
    bit crw [NPAGE];
    logic [MEM_AW-1:0] base_cfg;
    int len_cfg;

    task automatic model_flush();
        for (int i = 0; i < NPAGE; i++) cached[i] = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        model_flush();
    endtask

    task automatic xreq(input int p, input int off, input bit w);
        int r0, lcnt, ecause, efr, eread;
        bit erw, saw_busy_ready;
        logic [FRAME_W+1:0] pte;
        @(negedge clk);
        ptbr_i = base_cfg;
        ptlr_i = (PAGE_W+1)'(len_cfg);
        req_valid_i = 1'b1;
        req_addr_i  = LA_W'((p << OFF_W) | off);
        req_write_i = w;
        r0 = reads;
        @(negedge clk);
        req_valid_i = 1'b0;
        ptbr_i = ~base_cfg;
        ptlr_i = '0;
        lcnt = 1;
        saw_busy_ready = 1'b0;
        while (!rsp_valid_o && lcnt < 50) begin
            if (mem_rd_req_o && req_ready_o) saw_busy_ready = 1'b1;
            @(negedge clk);
            lcnt++;
        end
        efr = 0; erw = 1'b0; ecause = 0; eread = 0;
        if (p >= len_cfg) begin
            ecause = 1;
        end else if (cached[p]) begin
            efr = cfr[p]; erw = crw[p];
            ecause = (w && !erw) ? 3 : 0;
        end else begin
            eread = 1;
            pte = pt_mem[8'(base_cfg + MEM_AW'(p))];
            if (!pte[0]) begin
                ecause = 2;
            end else begin
                efr = int'(pte[FRAME_W+1:2]); erw = pte[1];
                cached[p] = 1'b1; cfr[p] = efr; crw[p] = erw;
                ecause = (w && !erw) ? 3 : 0;
            end
        end
        check(rsp_valid_o === 1'b1, "R8 response present", int'(rsp_valid_o), 1);
        check(int'(rsp_cause_o) == ecause, "R2/R4/R5 cause", int'(rsp_cause_o), ecause);
        check(rsp_fault_o === (ecause != 0), "R8 fault flag", int'(rsp_fault_o), int'(ecause != 0));
        if (ecause == 0)
            check(int'(rsp_paddr_o) == ((efr << OFF_W) | off), "R1 physical address",
                  int'(rsp_paddr_o), (efr << OFF_W) | off);
        if (eread == 0) begin
            check(reads - r0 == 0, "R6 no table read on hit or bound", reads - r0, 0);
            check(lcnt == 1, "R6 one-cycle latency", lcnt, 1);
        end else begin
            check(reads - r0 == 1, "R3 one table read on miss", reads - r0, 1);
            check(int'(last_addr) == int'(8'(base_cfg + MEM_AW'(p))), "R3 R9 entry address",
                  int'(last_addr), int'(8'(base_cfg + MEM_AW'(p))));
            check(!saw_busy_ready, "R9 ready low while walking", int'(saw_busy_ready), 0);
        end
        @(negedge clk);
        check(rsp_valid_o === 1'b0, "R8 single-cycle response", int'(rsp_valid_o), 0);
        ptbr_i = base_cfg;
        ptlr_i = (PAGE_W+1)'(len_cfg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0; req_write_i = 1'b0;
        ptbr_i = '0; ptlr_i = '0; flush_i = 1'b0; lat = 0;
        base_cfg = '0; len_cfg = 0;
        for (int i = 0; i < 256; i++) pt_mem[i] = '0;
        model_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready_o === 1'b1, "R9 reset ready", int'(req_ready_o), 1);
        check(rsp_valid_o === 1'b0, "R8 reset no response", int'(rsp_valid_o), 0);
        check(mem_rd_req_o === 1'b0, "R3 reset no read", int'(mem_rd_req_o), 0);

        // R10 sweep: misses fill, second pass hits; invalid pages never cached
        for (int cfg = 0; cfg < 2; cfg++) begin
            base_cfg = cfg ? 8'hF0 : 8'h1C;
            for (int len = 0; len <= NPAGE; len++) begin
                len_cfg = len;
                for (int p = 0; p < NPAGE; p++) begin
                    pt_mem[8'(base_cfg + MEM_AW'(p))] = {3'((p*3 + cfg*5 + len) & 7),
                        1'((p + cfg) & 1), 1'(p != ((len + cfg) % NPAGE))};
                end
                pulse_flush();
                for (int pass = 0; pass < 2; pass++) begin
                    for (int p = 0; p < NPAGE; p++) begin
                        for (int off = 0; off < (1 << OFF_W); off++) begin
                            for (int w = 0; w < 2; w++) begin
                                lat = (p + off + w) % 3;
                                xreq(p, off, 1'(w));
                            end
                        end
                    end
                end
            end
        end

        // R6 stale mapping used after table change; R7 flush forces a new read
        base_cfg = 8'h1C; len_cfg = NPAGE;
        pulse_flush();
        pt_mem[8'h1C] = {3'd5, 1'b1, 1'b1};
        xreq(0, 1, 1'b0);
        pt_mem[8'h1C] = {3'd2, 1'b1, 1'b1};
        xreq(0, 1, 1'b0);
        check(int'(rsp_paddr_o) == 0, "R6 response cleared after pulse", int'(rsp_paddr_o), 0);
        pulse_flush();
        xreq(0, 1, 1'b0);
        xreq(0, 3, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule